// File: doc/BRIEF.md
# Double-Buffered SPI Slave Port

This block lets a processor exchange fixed 16-bit words with an external SPI master. The master drives the serial clock, the active-low select and the serial input. The block answers on its serial output from a shift register, which is fed by a one-word holding register. Both the processor's writes and its reads go through one data address. A write fills the transmit path. A read returns the most recently accepted received frame. A second address returns the status flags.

All serial inputs pass through two-flop synchronizers into the system clock. Edges of the serial clock are detected in that domain. Each completed frame reloads the shifter from the holding register, and the reload happens at the end of the frame. A word that software writes in reply to a received frame therefore appears on the wire two frames later. Receive-full and transmit-empty share one interrupt output. A frame that completes while unread data is pending raises an overrun flag. A frame that is cut short by the select going high leaves every flag and register as it was.

Top module: `spi_dbuf_slave`

## Requirements
- R1: A frame is 16 bits in SPI mode 0. The block samples `mosi` on the rising `sck` edge, updates `miso` after the falling edge and sends the MSB first. It takes part only while `ss_n` is low, and `miso` is held at 0 while `ss_n` is high.
- R2: A read with `reg_addr`=1 returns on `reg_rdata` the last received frame that was accepted.
- R3: A read with `reg_addr`=0 returns the status word. Bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is overrun, and all other bits are 0. The first data write after reset that happens while `ss_n` is high and before any frame has completed goes straight into the shifter and leaves transmit-empty set. Every other data write goes into the holding register and clears transmit-empty.
- R4: At the end of each complete frame, the shifter is loaded from the holding register if that register holds a word, and with all zeros if it does not. The holding register is then empty. A word written after reading frame N is sent in frame N+2.
- R5: Receive-full is set when a frame completes. It clears only when a status read that saw it set is followed by a data read. A data read with no such status read before it leaves the flag set.
- R6: If a frame completes while receive-full is set, the overrun bit is set and the older received word is kept. Overrun clears together with receive-full.
- R7: Transmit-empty is 1 after reset. A data read sets it if the holding register is empty. The end of a frame does not set it.
- R8: `irq` is high exactly when receive-full or transmit-empty is set.
- R9: If `ss_n` rises before the 16th bit, the partial frame is discarded. No flag changes, the received word is unchanged and the shifter is not reloaded, so the next full frame sends the same word from its first bit.
- R10: A data write while the holding register already holds a word replaces that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| reg_addr | input | 1 | 0 = status word, 1 = data register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected address |
| irq | output | 1 | Combined receive-full / transmit-empty interrupt |

## Verification
The bench aims at the two-frame reply lag. A design that reloads the shifter straight from a write, or that reloads it at the start of a frame, would send the reply one frame early. It also preloads two words before any clocking to cover the reset-time fall-through. A design that cannot load the shifter directly would send zero first and shift every reply by one frame. Further tests are a data read with no status read before it, back-to-back frames with nothing read in between, and a select that rises after five bits. Wrong clearing would drop receive-full too early. A wrong overrun would overwrite the held word. A wrong abort would raise receive-full or restart transmission from the middle of a word.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int ST_RXF = 0;
  localparam int ST_TXE = 1;
  localparam int ST_OVR = 2;

  typedef enum logic {
    ADDR_STATUS = 1'b0,
    ADDR_DATA   = 1'b1
  } reg_addr_e;

  function automatic logic [2:0] pack_status(input logic rxf, input logic txe, input logic ovr);
    logic [2:0] s;
    s         = '0;
    s[ST_RXF] = rxf;
    s[ST_TXE] = txe;
    s[ST_OVR] = ovr;
    return s;
  endfunction
endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_dbuf_shift.sv
module spi_dbuf_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_word,
  output logic              miso,
  output logic              sel_active,
  output logic              frame_done,
  output logic              frame_abort,
  output logic [DATA_W-1:0] rx_word_nxt
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt, out_pos;
  logic [DATA_W-1:0] rx_shift, tx_word, tx_view;

  assign sel_active  = ~ss_n_s;
  assign sck_rise    = sck_s & ~sck_q;
  assign sck_fall    = ~sck_s & sck_q;
  assign frame_done  = sel_active & sck_rise & (bit_cnt == CNT_W'(DATA_W - 1));
  assign frame_abort = ~sel_active & (bit_cnt != '0);
  assign rx_word_nxt = {rx_shift[DATA_W-2:0], mosi_s};
  assign tx_view     = tx_word << out_pos;
  assign miso        = sel_active & tx_view[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      bit_cnt  <= '0;
      out_pos  <= '0;
      rx_shift <= '0;
      tx_word  <= '0;
    end else begin
      sck_q <= sck_s;
      if (!sel_active) begin
        bit_cnt <= '0;
        out_pos <= '0;
      end else if (sck_rise) begin
        rx_shift <= rx_word_nxt;
        if (frame_done) begin
          bit_cnt <= '0;
          out_pos <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (sck_fall) begin
        out_pos <= bit_cnt;
      end
      if (load_en) tx_word <= load_word;
    end
  end
endmodule

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_done,
  input  logic              sel_active,
  input  logic [DATA_W-1:0] rx_word_nxt,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              load_en,
  output logic [DATA_W-1:0] load_word,
  output logic              direct_load,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              overrun,
  output logic [DATA_W-1:0] rx_data
);
  logic              data_rd, stat_rd, data_wr, clear_rx, rxf_eff;
  logic              arm, sh_free, hold_v;
  logic [DATA_W-1:0] hold;

  assign data_rd     = reg_rd & (reg_addr == ADDR_DATA);
  assign stat_rd     = reg_rd & (reg_addr == ADDR_STATUS);
  assign data_wr     = reg_wr & (reg_addr == ADDR_DATA);
  assign clear_rx    = data_rd & arm;
  assign rxf_eff     = rx_full & ~clear_rx;
  assign direct_load = data_wr & sh_free & ~sel_active;
  assign load_en     = direct_load | frame_done;
  assign load_word   = frame_done ? (hold_v ? hold : '0) : reg_wdata;
  assign irq         = rx_full | tx_empty;
  assign reg_rdata   = (reg_addr == ADDR_DATA) ? rx_data
                     : DATA_W'(pack_status(rx_full, tx_empty, overrun));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      rx_data  <= '0;
      hold     <= '0;
      hold_v   <= 1'b0;
      sh_free  <= 1'b1;
      tx_empty <= 1'b1;
    end else begin
      if (data_rd)      arm <= 1'b0;
      else if (stat_rd) arm <= rx_full;

      if (clear_rx) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (frame_done) begin
        if (rxf_eff) overrun <= 1'b1;
        else begin
          rx_data <= rx_word_nxt;
          rx_full <= 1'b1;
        end
      end

      if (frame_done)  hold_v  <= 1'b0;
      if (load_en)     sh_free <= 1'b0;
      if (data_rd)     tx_empty <= ~hold_v;
      if (data_wr && !direct_load) begin
        hold     <= reg_wdata;
        hold_v   <= 1'b1;
        tx_empty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dbuf_slave.sv
module spi_dbuf_slave #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              sck_s, ss_n_s, mosi_s;
  logic              sel_active, frame_done, frame_abort;
  logic              load_en, direct_load;
  logic [DATA_W-1:0] load_word, rx_word_nxt, rx_data;
  logic              rx_full, tx_empty, overrun;

  spi_dbuf_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sck, ss_n, mosi}),
    .q_out ({sck_s, ss_n_s, mosi_s})
  );

  spi_dbuf_shift #(.DATA_W(DATA_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_s       (sck_s),
    .ss_n_s      (ss_n_s),
    .mosi_s      (mosi_s),
    .load_en     (load_en),
    .load_word   (load_word),
    .miso        (miso),
    .sel_active  (sel_active),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .rx_word_nxt (rx_word_nxt)
  );

  spi_dbuf_regs #(.DATA_W(DATA_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .frame_done  (frame_done),
    .sel_active  (sel_active),
    .rx_word_nxt (rx_word_nxt),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .load_en     (load_en),
    .load_word   (load_word),
    .direct_load (direct_load),
    .rx_full     (rx_full),
    .tx_empty    (tx_empty),
    .overrun     (overrun),
    .rx_data     (rx_data)
  );
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              frame_done,
  input logic              frame_abort,
  input logic              direct_load,
  input logic              rx_full,
  input logic              tx_empty,
  input logic              overrun,
  input logic [DATA_W-1:0] rx_data
);
  a_r2_rxdata_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $past(frame_done));

  a_r5_rxfull_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(frame_done));

  a_r6_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !(reg_rd && reg_addr)) |=> (overrun && $stable(rx_data)));

  a_r7_te_set_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(reg_rd && reg_addr));

  a_r3_write_clears_te: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !direct_load) |=> !tx_empty);

  a_r9_abort_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !$rose(rx_full));

  a_r9_abort_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, frame_abort}));
endmodule

bind spi_dbuf_slave spi_dbuf_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .frame_done  (frame_done),
  .frame_abort (frame_abort),
  .direct_load (direct_load),
  .rx_full     (rx_full),
  .tx_empty    (tx_empty),
  .overrun     (overrun),
  .rx_data     (rx_data)
);

// File: tb/test_spi_dbuf_slave.sv
module test_spi_dbuf_slave;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, sck, ss_n, mosi, miso;
  logic         reg_addr, reg_wr, reg_rd, irq;
  logic [W-1:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  spi_dbuf_slave #(.DATA_W(W)) i_spi_dbuf_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [W-1:0] m_sh, m_hold, m_rxd;
  logic         m_hv, m_free, m_rxf, m_ovr, m_te, m_arm;

  function automatic logic [W-1:0] reload_val(input logic hv, input logic [W-1:0] h);
    return hv ? h : '0;
  endfunction

  function automatic logic [W-1:0] status_of(input logic rxf, input logic te, input logic ovr);
    return {13'd0, ovr, te, rxf};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; sck = 0; ss_n = 1; mosi = 0;
    reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    m_sh = '0; m_hold = '0; m_rxd = '0; m_hv = 0; m_free = 1;
    m_rxf = 0; m_ovr = 0; m_te = 1; m_arm = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cpu_rd(input logic a, output logic [W-1:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic cpu_wr(input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = 1; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic spi_xfer(input logic [W-1:0] w, input int nbits, output logic [W-1:0] got);
    got = '0;
    @(negedge clk);
    ss_n = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[W-1-i];
      repeat (8) @(negedge clk);
      got[W-1-i] = miso;
      sck = 1;
      repeat (8) @(negedge clk);
      sck = 0;
    end
    repeat (6) @(negedge clk);
    ss_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic m_status_read();
    logic [W-1:0] v;
    cpu_rd(0, v);
    chk("R3 R5 R6 R7 status word", v, status_of(m_rxf, m_te, m_ovr));
    m_arm = m_rxf;
    chk("R8 irq", {15'd0, irq}, {15'd0, m_rxf | m_te});
  endtask

  task automatic m_data_read();
    logic [W-1:0] v;
    cpu_rd(1, v);
    chk("R2 received word", v, m_rxd);
    if (m_arm) begin m_rxf = 0; m_ovr = 0; end
    m_arm = 0;
    m_te = !m_hv;
    chk("R8 irq after data read", {15'd0, irq}, {15'd0, m_rxf | m_te});
  endtask

  task automatic m_write(input logic [W-1:0] d);
    cpu_wr(d);
    if (m_free) begin m_sh = d; m_free = 0; end
    else begin m_hold = d; m_hv = 1; m_te = 0; end
  endtask

  task automatic m_frame(input string tag, input logic [W-1:0] w);
    logic [W-1:0] got;
    spi_xfer(w, W, got);
    chk(tag, got, m_sh);
    m_sh = reload_val(m_hv, m_hold);
    m_hv = 0; m_free = 0;
    if (m_rxf) m_ovr = 1;
    else begin m_rxd = w; m_rxf = 1; end
    chk("R1 miso low when deselected", {15'd0, miso}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // reset state
    m_status_read();
    chk("R1 miso idle after reset", {15'd0, miso}, '0);

    // reply lag with no preload: 0, 0, then words written after each read
    for (int k = 0; k < 4; k++) begin
      m_frame("R4 two-frame reply lag", 16'hA5C0 + 16'(k));
      m_status_read();
      m_data_read();
      m_write(16'h1111 * 16'(k + 1));
    end

    // two preloaded words before any clocking
    do_reset();
    m_write(16'hBEEF);
    m_status_read();             // R3: transmit-empty still set
    m_write(16'hCAFE);
    m_status_read();             // R3: transmit-empty now clear
    m_frame("R3 preload first word", 16'h0F0F);
    m_frame("R3 preload second word", 16'hF0F0);
    m_status_read();             // R6: overrun, older word kept
    m_data_read();
    m_frame("R4 zeros when holding empty", 16'h1234);
    // R5: data read without status read keeps receive-full
    m_data_read();
    m_status_read();
    m_data_read();
    m_status_read();

    // R9: abort mid-frame
    do_reset();
    m_write(16'h8001);
    m_write(16'h4002);
    begin
      logic [W-1:0] junk;
      spi_xfer(16'hFFFF, 5, junk);
    end
    m_status_read();             // R9: no flag change after abort
    m_frame("R9 full word after abort", 16'h5555);
    m_status_read();
    m_data_read();

    // R10: overwrite of a full holding register
    do_reset();
    m_write(16'h0101);
    m_write(16'h0202);
    m_write(16'h0303);
    m_status_read();
    m_frame("R10 first word", 16'h7777);
    m_frame("R10 overwritten holding word", 16'h8888);

    // constrained random mix
    do_reset();
    for (int it = 0; it < 40; it++) begin
      logic [W-1:0] w;
      w = 16'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        logic [W-1:0] junk;
        spi_xfer(w, $urandom_range(1, W - 1), junk);
        m_status_read();         // R9: abort leaves flags
      end
      m_frame("R4 random frame", w);
      if ($urandom_range(0, 3) != 0) m_status_read();
      if ($urandom_range(0, 3) != 0) m_data_read();
      if ($urandom_range(0, 3) != 0) m_write(16'($urandom));
      if ($urandom_range(0, 5) == 0) m_write(16'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule